// File: doc/BRIEF.md
# Multichannel Ping-Pong DMA Engine

This block moves 32-bit words from one address to another on behalf of up to sixteen channels. Each channel owns a pair of descriptors ("packets"). Each packet holds a source address, a destination address, an element count, two address-advance enables, a trigger mode and an interrupt enable. When a channel exhausts one packet, it switches to its partner packet if the CPU has refilled it. Software can therefore keep one buffer filling while it drains the other. The engine raises a short interrupt at each boundary.

A packet runs in one of two modes. In the free-running (memory-to-memory) mode it moves elements back to back. In the triggered (peripheral) mode it moves one element for each strobe on the channel's request input. A fixed-priority arbiter grants one element at a time, and the lowest channel number wins. Each element is a single read followed by a single write on a simple memory port with one cycle of read latency. The engine performs no access that touches a protected address window. It marks the offending channel as faulted instead.

Top module: `pp_dma`

## Requirements
- R1: While and just after `rst` is high, `irq`, `chan_busy`, `chan_err`, `pkt_done`, `mem_rd_en` and `mem_wr_en` are all zero.
- R2: A free-running packet of N elements copies the words at src, src+4, … to dst, dst+4, … once its channel is started, with no request strobe needed.
- R3: Packet index is 2*channel+slot. `start` loads slot 0 if it is valid, otherwise slot 1. When a packet completes, its valid bit clears. The channel then loads the partner slot if it is valid, or goes idle. A consumed packet is not run again by a later `start`.
- R4: Completing a packet sets its `pkt_done` bit. `irq[ch]` pulses for exactly one cycle only if that packet's interrupt enable was set.
- R5: A triggered packet moves no element without a request. Requests that arrive while one is still pending merge into one element.
- R6: Among ready channels, the lowest-numbered one is granted, one element per grant.
- R7: The source or destination address advances by 4 after each element only when its advance enable is set. Otherwise it stays fixed.
- R8: If the granted channel's source or destination lies in [PROT_LO, PROT_HI], no memory access is made. In that case `chan_err[ch]` sets and the channel goes idle. A later `start` of the channel clears the error.
- R9: A packet write to the packet a channel is currently running is ignored. A write to any other packet stores it and clears its `pkt_done` bit. A packet written with count zero is stored as not valid.
- R10: The read of an element is issued one cycle after its grant. The write follows the read by exactly two cycles. A read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Packet write strobe |
| cfg_ch | input | CHW | Channel of the packet being written |
| cfg_slot | input | 1 | Slot (0 or 1) of the packet being written |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_cnt | input | CW | Element count |
| cfg_src_inc | input | 1 | Advance source after each element |
| cfg_dst_inc | input | 1 | Advance destination after each element |
| cfg_req_mode | input | 1 | 1: one element per request, 0: free-running |
| cfg_irq_en | input | 1 | Pulse interrupt when this packet completes |
| cfg_valid | input | 1 | Mark the written packet valid |
| start | input | NCH | Per-channel start pulse |
| req | input | NCH | Per-channel request strobe |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Read data, valid the cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |
| irq | output | NCH | Per-channel completion interrupt pulse |
| chan_err | output | NCH | Per-channel protection fault flag |
| pkt_done | output | 2*NCH | Per-packet completion flag |
| chan_busy | output | NCH | Channel is running a packet |
| chan_slot | output | NCH | Slot the channel is running |

## Verification
The bench builds the engine with its defaults: sixteen channels, a 4-byte address step, and the protected window at the top 64 KiB of the address space. These defaults let it drive a low channel in free-running mode against a higher channel in triggered mode, so starvation and request merging become visible in the write order. Placing a destination just above 0xFFFF_0000 exercises the fault path, while every legal buffer sits in a 4 KiB model memory. The two-packet chain, packet consumption, write rejection on a running packet and zero-count packets are all reached through channel numbers spread across the range.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 16;

  typedef struct packed {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [CW-1:0] cnt;
    logic          src_inc;
    logic          dst_inc;
    logic          req_mode;
    logic          irq_en;
    logic          vld;
  } pkt_t;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_CAPT, S_WRITE} eng_state_t;
endpackage

// File: rtl/pp_dma_pktstore.sv
module pp_dma_pktstore import pp_dma_pkg::*; #(
  parameter int NPKT = 32,
  parameter int PW   = $clog2(NPKT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [PW-1:0]   wr_idx,
  input  pkt_t            wr_pkt,
  input  logic [NPKT-1:0] busy_mask,
  input  logic [NPKT-1:0] cmpl_mask,
  output pkt_t            pkts [NPKT],
  output logic [NPKT-1:0] done
);
  pkt_t wr_fix;
  logic wr_ok;

  always_comb begin
    wr_fix     = wr_pkt;
    wr_fix.vld = wr_pkt.vld & (wr_pkt.cnt != '0);
    wr_ok      = wr_en && !busy_mask[wr_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NPKT; k++) pkts[k] <= '0;
      done <= '0;
    end else begin
      for (int k = 0; k < NPKT; k++) begin
        if (cmpl_mask[k]) begin
          pkts[k].vld <= 1'b0;
          done[k]     <= 1'b1;
        end
      end
      if (wr_ok) begin
        pkts[wr_idx] <= wr_fix;
        done[wr_idx] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan import pp_dma_pkg::*; #(
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          req,
  input  pkt_t          pk [2],
  input  logic          gnt,
  input  logic          flt,
  input  logic          fin,
  output logic          ready,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic          active,
  output logic          slot,
  output logic          cmpl,
  output logic          irq,
  output logic          err
);
  logic [CW-1:0] rem;
  logic          sinc, dinc, reqm, ien, pend;
  logic          ld_go, ld_slot;
  pkt_t          ld_pkt;

  always_comb begin
    cmpl    = active & fin & (rem == '0);
    ld_go   = 1'b0;
    ld_slot = 1'b0;
    if (start && !active) begin
      if (pk[0].vld) begin
        ld_go = 1'b1;
      end else if (pk[1].vld) begin
        ld_go   = 1'b1;
        ld_slot = 1'b1;
      end
    end else if (cmpl && pk[slot ^ 1'b1].vld) begin
      ld_go   = 1'b1;
      ld_slot = slot ^ 1'b1;
    end
    ld_pkt = pk[ld_slot];
    ready  = active & (~reqm | pend);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; slot <= 1'b0; src <= '0; dst <= '0; rem <= '0;
      sinc <= 1'b0; dinc <= 1'b0; reqm <= 1'b0; ien <= 1'b0;
      pend <= 1'b0; irq <= 1'b0; err <= 1'b0;
    end else begin
      irq <= cmpl & ien;
      if (start && !active) err <= 1'b0;
      if (ld_go) begin
        active <= 1'b1;
        slot   <= ld_slot;
        src    <= ld_pkt.src;
        dst    <= ld_pkt.dst;
        rem    <= ld_pkt.cnt;
        sinc   <= ld_pkt.src_inc;
        dinc   <= ld_pkt.dst_inc;
        reqm   <= ld_pkt.req_mode;
        ien    <= ld_pkt.irq_en;
        pend   <= active ? (pend | req) : 1'b0;
      end else if (cmpl) begin
        active <= 1'b0;
        pend   <= 1'b0;
      end else if (gnt && flt) begin
        err    <= 1'b1;
        active <= 1'b0;
        pend   <= 1'b0;
      end else if (active) begin
        pend <= reqm & (req | (pend & ~gnt));
        if (gnt) begin
          rem <= rem - CW'(1);
          if (sinc) src <= src + AW'(STEP);
          if (dinc) dst <= dst + AW'(STEP);
        end
      end
    end
  end
endmodule

// File: rtl/pp_dma_arb.sv
module pp_dma_arb #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  gnt
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
    gnt = any ? (N'(1) << idx) : '0;
  end
endmodule

// File: rtl/pp_dma.sv
module pp_dma import pp_dma_pkg::*; #(
  parameter int            NCH     = 16,
  parameter int            STEP    = 4,
  parameter logic [AW-1:0] PROT_LO = 32'hFFFF_0000,
  parameter logic [AW-1:0] PROT_HI = 32'hFFFF_FFFF,
  parameter int            CHW     = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CHW-1:0]   cfg_ch,
  input  logic             cfg_slot,
  input  logic [AW-1:0]    cfg_src,
  input  logic [AW-1:0]    cfg_dst,
  input  logic [CW-1:0]    cfg_cnt,
  input  logic             cfg_src_inc,
  input  logic             cfg_dst_inc,
  input  logic             cfg_req_mode,
  input  logic             cfg_irq_en,
  input  logic             cfg_valid,
  input  logic [NCH-1:0]   start,
  input  logic [NCH-1:0]   req,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic [DW-1:0]    mem_rd_data,
  output logic             mem_wr_en,
  output logic [AW-1:0]    mem_wr_addr,
  output logic [DW-1:0]    mem_wr_data,
  output logic [NCH-1:0]   irq,
  output logic [NCH-1:0]   chan_err,
  output logic [2*NCH-1:0] pkt_done,
  output logic [NCH-1:0]   chan_busy,
  output logic [NCH-1:0]   chan_slot
);
  localparam int NPKT = 2 * NCH;
  localparam int PW   = $clog2(NPKT);

  pkt_t            pkts [NPKT];
  pkt_t            wr_pkt;
  logic [PW-1:0]   wr_idx;
  logic [NPKT-1:0] busy_mask, cmpl_mask;
  logic [NCH-1:0]  ready, cmpl, fin_r, cur_oh, arb_req, arb_gnt;
  logic [AW-1:0]   ch_src [NCH];
  logic [AW-1:0]   ch_dst [NCH];
  logic [CHW-1:0]  sel;
  logic            arb_any, flt;
  logic [AW-1:0]   dst_hold;
  eng_state_t      st;

  function automatic logic in_win(input logic [AW-1:0] a);
    return (a >= PROT_LO) && (a <= PROT_HI);
  endfunction

  always_comb begin
    wr_pkt.src      = cfg_src;
    wr_pkt.dst      = cfg_dst;
    wr_pkt.cnt      = cfg_cnt;
    wr_pkt.src_inc  = cfg_src_inc;
    wr_pkt.dst_inc  = cfg_dst_inc;
    wr_pkt.req_mode = cfg_req_mode;
    wr_pkt.irq_en   = cfg_irq_en;
    wr_pkt.vld      = cfg_valid;
    wr_idx          = PW'({cfg_ch, cfg_slot});
  end

  pp_dma_pktstore #(.NPKT(NPKT), .PW(PW)) u_store (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_idx(wr_idx), .wr_pkt(wr_pkt),
    .busy_mask(busy_mask), .cmpl_mask(cmpl_mask), .pkts(pkts), .done(pkt_done)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pkt_t pair [2];
    assign pair[0] = pkts[2*i];
    assign pair[1] = pkts[2*i+1];

    pp_dma_chan #(.STEP(STEP)) u_ch (
      .clk(clk), .rst(rst), .start(start[i]), .req(req[i]), .pk(pair),
      .gnt(arb_gnt[i]), .flt(flt), .fin(fin_r[i]), .ready(ready[i]),
      .src(ch_src[i]), .dst(ch_dst[i]), .active(chan_busy[i]),
      .slot(chan_slot[i]), .cmpl(cmpl[i]), .irq(irq[i]), .err(chan_err[i])
    );

    assign busy_mask[2*i]   = chan_busy[i] & ~chan_slot[i];
    assign busy_mask[2*i+1] = chan_busy[i] &  chan_slot[i];
    assign cmpl_mask[2*i]   = cmpl[i] & ~chan_slot[i];
    assign cmpl_mask[2*i+1] = cmpl[i] &  chan_slot[i];
  end

  assign arb_req = ready & {NCH{st == S_IDLE}};

  pp_dma_arb #(.N(NCH), .IW(CHW)) u_arb (
    .req(arb_req), .any(arb_any), .idx(sel), .gnt(arb_gnt)
  );

  assign flt = in_win(ch_src[sel]) || in_win(ch_dst[sel]);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
      dst_hold    <= '0;
      cur_oh      <= '0;
      fin_r       <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      fin_r     <= '0;
      case (st)
        S_IDLE: begin
          if (arb_any && !flt) begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= ch_src[sel];
            dst_hold    <= ch_dst[sel];
            cur_oh      <= arb_gnt;
            st          <= S_READ;
          end
        end
        S_READ: st <= S_CAPT;
        S_CAPT: begin
          mem_wr_en   <= 1'b1;
          mem_wr_addr <= dst_hold;
          mem_wr_data <= mem_rd_data;
          fin_r       <= cur_oh;
          st          <= S_WRITE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pp_dma_sva.sv
module pp_dma_sva import pp_dma_pkg::*; #(
  parameter int            NCH     = 16,
  parameter logic [AW-1:0] PROT_LO = 32'hFFFF_0000,
  parameter logic [AW-1:0] PROT_HI = 32'hFFFF_FFFF
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_rd_en,
  input logic [AW-1:0]    mem_rd_addr,
  input logic             mem_wr_en,
  input logic [AW-1:0]    mem_wr_addr,
  input logic [NCH-1:0]   irq,
  input logic [2*NCH-1:0] pkt_done,
  input logic [NCH-1:0]   chan_busy,
  input logic [NCH-1:0]   chan_err
);
  assert_no_wr_in_window_R8: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> !((mem_wr_addr >= PROT_LO) && (mem_wr_addr <= PROT_HI)));

  assert_no_rd_in_window_R8: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !((mem_rd_addr >= PROT_LO) && (mem_rd_addr <= PROT_HI)));

  assert_rd_wr_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

  assert_wr_after_rd_R10: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> $past(mem_rd_en, 2));

  assert_irq_single_R4: assert property (@(posedge clk) disable iff (rst)
    (irq != '0) |=> ((irq & $past(irq)) == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_irq_has_done_R4: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> (pkt_done[2*i] || pkt_done[2*i+1]));

    assert_err_stops_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(chan_err[i]) |-> !chan_busy[i]);
  end
endmodule

bind pp_dma pp_dma_sva #(.NCH(NCH), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)) u_sva (
  .clk(clk), .rst(rst), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .irq(irq),
  .pkt_done(pkt_done), .chan_busy(chan_busy), .chan_err(chan_err)
);

// File: tb/pp_dma_tb.sv
module pp_dma_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_ch;
  logic        cfg_slot;
  logic [31:0] cfg_src, cfg_dst;
  logic [15:0] cfg_cnt;
  logic        cfg_src_inc, cfg_dst_inc, cfg_req_mode, cfg_irq_en, cfg_valid;
  logic [15:0] start, req;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
  logic [31:0] mem_rd_data;
  logic [15:0] irq, chan_err, chan_busy, chan_slot;
  logic [31:0] pkt_done;

  always #10 clk = ~clk;

  pp_dma u_dut (.*);

  int nchk = 0, nerr = 0, cyc = 0, nwr = 0, viol = 0;
  bit finished = 0;
  logic [31:0] mem [1024];
  int wcyc [1024];
  int irqcnt [16];
  logic rd_d1 = 1'b0, rd_d2 = 1'b0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'h5A00_0000 | {2'b00, a[31:2]};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(32'(i) << 2);
      mem_rd_data <= '0;
    end else begin
      if (mem_wr_en && !rd_d2) viol++;
      if (mem_wr_en && mem_rd_en) viol++;
      if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[11:2]];
      if (mem_wr_en) begin
        mem[mem_wr_addr[11:2]] <= mem_wr_data;
        wcyc[mem_wr_addr[11:2]] = cyc;
        nwr++;
      end
      for (int i = 0; i < 16; i++) if (irq[i]) irqcnt[i]++;
    end
    rd_d2 = rd_d1;
    rd_d1 = mem_rd_en;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_pkt(input int ch, input int sl, input logic [31:0] s, input logic [31:0] d,
                           input int cnt, input bit si, input bit di, input bit rm,
                           input bit ie, input bit v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 4'(ch); cfg_slot = sl[0]; cfg_src = s; cfg_dst = d;
    cfg_cnt = 16'(cnt); cfg_src_inc = si; cfg_dst_inc = di; cfg_req_mode = rm;
    cfg_irq_en = ie; cfg_valid = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic kick(input int ch);
    @(negedge clk); start[ch] = 1'b1;
    @(negedge clk); start[ch] = 1'b0;
  endtask

  task automatic pulse_req(input int ch);
    @(negedge clk); req[ch] = 1'b1;
    @(negedge clk); req[ch] = 1'b0;
  endtask

  task automatic wait_idle(input int ch);
    for (int n = 0; n < 500 && chan_busy[ch]; n++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 chan_busy", 32'(chan_busy), 0);
    chk("R1 chan_err", 32'(chan_err), 0);
    chk("R1 pkt_done", pkt_done, 0);
    chk("R1 mem strobes", {30'd0, mem_rd_en, mem_wr_en}, 0);
  endtask

  task automatic t_copy;
    int w0, i0;
    write_pkt(3, 0, 32'h040, 32'h800, 4, 1, 1, 0, 1, 1);
    w0 = nwr; i0 = irqcnt[3];
    kick(3); wait_idle(3); repeat (2) @(negedge clk);
    for (int k = 0; k < 4; k++)
      chk("R2 copied word", mem[(32'h800 >> 2) + k], pat(32'h040 + 32'(4 * k)));
    chk("R2 element count", 32'(nwr - w0), 4);
    chk("R4 done flag of packet 6", {31'd0, pkt_done[6]}, 1);
    chk("R4 one irq pulse", 32'(irqcnt[3] - i0), 1);
  endtask

  task automatic t_pingpong;
    int w0, i0;
    write_pkt(5, 0, 32'h100, 32'h900, 3, 1, 1, 0, 1, 1);
    write_pkt(5, 1, 32'h140, 32'h940, 2, 1, 1, 0, 0, 1);
    w0 = nwr; i0 = irqcnt[5];
    kick(5); wait_idle(5); repeat (2) @(negedge clk);
    chk("R3 slot0 data", mem[(32'h900 >> 2) + 2], pat(32'h108));
    chk("R3 slot1 data", mem[(32'h940 >> 2) + 1], pat(32'h144));
    chk("R3 both packets moved", 32'(nwr - w0), 5);
    chk("R3 both done", {30'd0, pkt_done[11], pkt_done[10]}, 3);
    chk("R4 irq only for enabled packet", 32'(irqcnt[5] - i0), 1);
    w0 = nwr;
    kick(5);
    chk("R3 consumed packets not rerun", {31'd0, chan_busy[5]}, 0);
    repeat (6) @(negedge clk);
    chk("R3 no writes after rerun", 32'(nwr - w0), 0);
    write_pkt(5, 0, 32'h100, 32'h900, 1, 1, 1, 0, 1, 1);
    @(negedge clk);
    chk("R9 write clears done", {30'd0, pkt_done[11], pkt_done[10]}, 2);
  endtask

  task automatic t_request;
    int w0, i0, last;
    write_pkt(2, 0, 32'h200, 32'hA00, 3, 1, 1, 1, 1, 1);
    write_pkt(0, 0, 32'h000, 32'hB00, 12, 1, 1, 0, 1, 1);
    w0 = nwr; i0 = irqcnt[2];
    kick(2); repeat (10) @(negedge clk);
    chk("R5 no element without request", 32'(nwr - w0), 0);
    kick(0); repeat (2) @(negedge clk);
    pulse_req(2); repeat (3) @(negedge clk);
    pulse_req(2); pulse_req(2);
    wait_idle(0); repeat (10) @(negedge clk);
    chk("R5 merged requests move one element", 32'(nwr - w0), 13);
    chk("R5 first element", mem[32'hA00 >> 2], pat(32'h200));
    chk("R5 second element untouched", mem[32'hA04 >> 2], pat(32'hA04));
    last = 0;
    for (int k = 0; k < 12; k++)
      if (wcyc[(32'hB00 >> 2) + k] > last) last = wcyc[(32'hB00 >> 2) + k];
    chk("R6 lower channel served first", {31'd0, wcyc[32'hA00 >> 2] > last}, 1);
    chk("R2 long copy last word", mem[(32'hB00 >> 2) + 11], pat(32'h02C));
    pulse_req(2); repeat (8) @(negedge clk);
    pulse_req(2); repeat (8) @(negedge clk);
    chk("R5 third element", mem[(32'hA00 >> 2) + 2], pat(32'h208));
    chk("R5 channel idle after count", {31'd0, chan_busy[2]}, 0);
    chk("R4 done and irq", {pkt_done[4], 31'(irqcnt[2] - i0)}, 32'h8000_0001);
  endtask

  task automatic t_fixed;
    int w0, i0;
    write_pkt(9, 0, 32'h300, 32'hC00, 3, 1, 0, 0, 0, 1);
    w0 = nwr; i0 = irqcnt[9];
    kick(9); wait_idle(9); repeat (2) @(negedge clk);
    chk("R7 fixed destination holds last word", mem[32'hC00 >> 2], pat(32'h308));
    chk("R7 next word untouched", mem[32'hC04 >> 2], pat(32'hC04));
    chk("R7 element count", 32'(nwr - w0), 3);
    chk("R4 no irq when disabled", 32'(irqcnt[9] - i0), 0);
  endtask

  task automatic t_protect;
    int w0;
    write_pkt(11, 0, 32'h3A0, 32'hFFFF_0010, 2, 1, 1, 0, 1, 1);
    w0 = nwr;
    kick(11); repeat (5) @(negedge clk);
    chk("R8 error flag", {31'd0, chan_err[11]}, 1);
    chk("R8 channel idle", {31'd0, chan_busy[11]}, 0);
    chk("R8 no done", {31'd0, pkt_done[22]}, 0);
    chk("R8 no access", 32'(nwr - w0), 0);
    write_pkt(11, 0, 32'h3A0, 32'hD00, 1, 1, 1, 0, 1, 1);
    kick(11);
    chk("R8 start clears error", {31'd0, chan_err[11]}, 0);
    wait_idle(11); repeat (2) @(negedge clk);
    chk("R8 recovered copy", mem[32'hD00 >> 2], pat(32'h3A0));
  endtask

  task automatic t_active;
    write_pkt(7, 0, 32'h380, 32'hE00, 2, 1, 1, 1, 1, 1);
    kick(7);
    write_pkt(7, 0, 32'h3C0, 32'hE00, 2, 1, 1, 1, 1, 1);
    pulse_req(7); repeat (8) @(negedge clk);
    pulse_req(7); repeat (8) @(negedge clk);
    chk("R9 running packet kept first word", mem[32'hE00 >> 2], pat(32'h380));
    chk("R9 running packet kept second word", mem[32'hE04 >> 2], pat(32'h384));
    chk("R9 channel finished", {31'd0, chan_busy[7]}, 0);
    write_pkt(8, 0, 32'h000, 32'hF00, 0, 1, 1, 0, 1, 1);
    kick(8);
    chk("R9 zero-count packet not valid", {31'd0, chan_busy[8]}, 0);
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_ch = '0; cfg_slot = 1'b0; cfg_src = '0;
    cfg_dst = '0; cfg_cnt = '0; cfg_src_inc = 1'b0; cfg_dst_inc = 1'b0;
    cfg_req_mode = 1'b0; cfg_irq_en = 1'b0; cfg_valid = 1'b0;
    start = '0; req = '0;
    for (int i = 0; i < 16; i++) irqcnt[i] = 0;
    for (int i = 0; i < 1024; i++) wcyc[i] = 0;
    repeat (4) @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_copy;
    t_pingpong;
    t_request;
    t_fixed;
    t_protect;
    t_active;
    chk("R10 read-to-write spacing and exclusivity", 32'(viol), 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule